// File: doc/BRIEF.md
# Multi-Precision Aliased Floating-Point Register File

This block is the floating-point register store of a processor core. One array of 64-bit entries can be viewed three ways: as 32-bit single registers, as 64-bit double registers or as 128-bit quad registers. The three views share the same bits, so a value written as a double can be read back as two singles, and a pair of doubles can be read as one quad. A write port and a read port each carry a two-bit precision code and a six-bit register number. Data moves on a 128-bit bus, right-aligned for the narrower precisions.

Register numbers count in 32-bit units at every precision. Precision code 0 selects single, 1 selects double, 2 selects quad, and 3 is reserved. The base configuration holds 16 doubles. A build parameter adds a second bank of 16 doubles. That bank is reachable only as doubles or quads. Any number that the chosen precision cannot reach sets an illegal flag on that port. An illegal write changes nothing, and an illegal read returns zero. Reads are combinational. A read that overlaps a write in the same cycle returns the newly written bits.

Top module: `fp_alias_regfile`

## Requirements
- R1: Single register n (n < 32) is one half of double n/2. An even n selects bits 63:32 of that double and an odd n selects bits 31:0. A single read returns the word in rd_data[31:0] with every upper bit zero.
- R2: A single write changes only its own 32-bit half. The other half of the same double keeps its value.
- R3: A double access (code 1) needs an even number n and addresses double n/2. The data sits in bits 63:0 of the bus, and bits 127:64 of a double read are zero.
- R4: A quad access (code 2) needs n to be a multiple of 4. It covers double n/2 in bits 127:64 and double n/2+1 in bits 63:0.
- R5: An odd double number, a quad number that is not a multiple of 4, or precision code 3 sets the illegal flag. A write raising the flag leaves all storage unchanged. A read raising the flag returns all zeros.
- R6: A single number of 32 or more is illegal in every configuration.
- R7: With the extended bank off, any double or quad that reaches beyond double 15 is illegal. With it on, doubles 0 to 31 and quads 0 to 60 are legal.
- R8: When a legal write and a read overlap in the same cycle, the read returns the new bits for the overlapping part and the stored bits for the rest.
- R9: A synchronous active-high reset clears every register to zero.
- R10: A legal write is stored at the next rising clock edge and stays readable until it is overwritten or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_prec | input | 2 | Write precision: 0 single, 1 double, 2 quad, 3 reserved |
| wr_num | input | 6 | Write register number in 32-bit units |
| wr_data | input | 128 | Write data, right-aligned for single and double |
| wr_illegal | output | 1 | Write requested to a number its precision cannot reach |
| rd_prec | input | 2 | Read precision, same coding as the write port |
| rd_num | input | 6 | Read register number in 32-bit units |
| rd_data | output | 128 | Read data, right-aligned and zero-extended |
| rd_illegal | output | 1 | Read number unreachable at the read precision |

## Verification
The assertions assume that the ports never carry X or Z values after reset. They also assume the write request is sampled only at rising edges, so the read mux and the write steering can be related within one cycle. The hold property further assumes that a read address kept steady with no write in flight means the caller expects stable data. The bench drives every input from the falling edge and sweeps all four precision codes across all 64 numbers. It runs two builds side by side, one with the extended bank and one without, so every legal and illegal case is covered by defined stimulus.

// File: rtl/fp_alias_pkg.sv
package fp_alias_pkg;

    typedef enum logic [1:0] {
        PREC_SGL  = 2'd0,
        PREC_DBL  = 2'd1,
        PREC_QUAD = 2'd2,
        PREC_RSVD = 2'd3
    } prec_e;

    // Decoded shape of one port access
    typedef struct packed {
        logic ok;       // reachable at this precision
        logic sgl;      // 32-bit view
        logic quad;     // 128-bit view, spans two entries
        logic lo_half;  // single view: low word of the entry
    } acc_kind_t;

    // Alignment rule on the two low number bits
    function automatic logic align_ok(prec_e p, logic [1:0] lsb);
        case (p)
            PREC_SGL:  return 1'b1;
            PREC_DBL:  return ~lsb[0];
            PREC_QUAD: return (lsb == 2'b00);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fp_alias_decode.sv
module fp_alias_decode
    import fp_alias_pkg::*;
#(
    parameter int NUM_W     = 6,
    parameter int NUM_DBL   = 16,
    parameter int SGL_LIMIT = 32,
    localparam int DIDX_W   = NUM_W - 1
) (
    input  logic [1:0]        prec_i,
    input  logic [NUM_W-1:0]  num_i,
    output acc_kind_t         kind_o,
    output logic [DIDX_W-1:0] didx_o
);

    localparam logic [DIDX_W:0] DBL_LIM = (DIDX_W+1)'(NUM_DBL);
    localparam logic [NUM_W:0]  SGL_LIM = (NUM_W+1)'(SGL_LIMIT);

    prec_e           p;
    logic [DIDX_W:0] last_idx;
    logic            in_range;

    always_comb begin
        p        = prec_e'(prec_i);
        didx_o   = num_i[NUM_W-1:1];
        last_idx = {1'b0, didx_o} + {{DIDX_W{1'b0}}, (p == PREC_QUAD)};
        case (p)
            PREC_SGL:  in_range = ({1'b0, num_i} < SGL_LIM);
            PREC_DBL,
            PREC_QUAD: in_range = (last_idx < DBL_LIM);
            default:   in_range = 1'b0;
        endcase
        kind_o.ok      = align_ok(p, num_i[1:0]) & in_range;
        kind_o.sgl     = (p == PREC_SGL);
        kind_o.quad    = (p == PREC_QUAD);
        kind_o.lo_half = num_i[0];
    end

endmodule

// File: rtl/fp_alias_overlay.sv
module fp_alias_overlay
    import fp_alias_pkg::*;
#(
    parameter int SGL_W   = 32,
    parameter int NUM_DBL = 16,
    parameter int DIDX_W  = 5,
    localparam int DBL_W  = 2 * SGL_W,
    localparam int QUAD_W = 4 * SGL_W
) (
    input  logic [DBL_W-1:0]  cur_i [NUM_DBL],
    input  logic              wr_en_i,
    input  acc_kind_t         kind_i,
    input  logic [DIDX_W-1:0] didx_i,
    input  logic [QUAD_W-1:0] data_i,
    output logic [DBL_W-1:0]  eff_o [NUM_DBL]
);

    logic            act;
    logic [DIDX_W:0] first_idx;
    logic [DIDX_W:0] second_idx;

    assign act        = wr_en_i & kind_i.ok;
    assign first_idx  = {1'b0, didx_i};
    assign second_idx = {1'b0, didx_i} + {{DIDX_W{1'b0}}, 1'b1};

    for (genvar i = 0; i < NUM_DBL; i++) begin : g_entry
        localparam logic [DIDX_W:0] IDX = (DIDX_W+1)'(i);
        logic             hit_first;
        logic             hit_second;
        logic [DBL_W-1:0] val;

        assign hit_first  = act & (first_idx == IDX);
        assign hit_second = act & kind_i.quad & (second_idx == IDX);

        always_comb begin
            val = cur_i[i];
            if (hit_second) begin
                val = data_i[DBL_W-1:0];
            end else if (hit_first) begin
                if (kind_i.quad) begin
                    val = data_i[QUAD_W-1:DBL_W];
                end else if (kind_i.sgl) begin
                    if (kind_i.lo_half)
                        val[SGL_W-1:0] = data_i[SGL_W-1:0];
                    else
                        val[DBL_W-1:SGL_W] = data_i[SGL_W-1:0];
                end else begin
                    val = data_i[DBL_W-1:0];
                end
            end
        end

        assign eff_o[i] = val;
    end

endmodule

// File: rtl/fp_alias_bank.sv
module fp_alias_bank #(
    parameter int DBL_W   = 64,
    parameter int NUM_DBL = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DBL_W-1:0] nxt_i [NUM_DBL],
    output logic [DBL_W-1:0] q_o   [NUM_DBL]
);

    for (genvar i = 0; i < NUM_DBL; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q_o[i] <= '0;
            else
                q_o[i] <= nxt_i[i];
        end
    end

endmodule

// File: rtl/fp_alias_rdmux.sv
module fp_alias_rdmux
    import fp_alias_pkg::*;
#(
    parameter int SGL_W   = 32,
    parameter int NUM_DBL = 16,
    parameter int DIDX_W  = 5,
    localparam int DBL_W  = 2 * SGL_W,
    localparam int QUAD_W = 4 * SGL_W
) (
    input  logic [DBL_W-1:0]  eff_i [NUM_DBL],
    input  acc_kind_t         kind_i,
    input  logic [DIDX_W-1:0] didx_i,
    output logic [QUAD_W-1:0] data_o
);

    logic [DBL_W-1:0] first_w;
    logic [DBL_W-1:0] second_w;
    logic [DIDX_W:0]  first_idx;
    logic [DIDX_W:0]  second_idx;

    always_comb begin
        first_idx  = {1'b0, didx_i};
        second_idx = {1'b0, didx_i} + {{DIDX_W{1'b0}}, 1'b1};
        first_w    = '0;
        second_w   = '0;
        for (int i = 0; i < NUM_DBL; i++) begin
            if (first_idx == (DIDX_W+1)'(i))  first_w  = eff_i[i];
            if (second_idx == (DIDX_W+1)'(i)) second_w = eff_i[i];
        end

        if (!kind_i.ok)
            data_o = '0;
        else if (kind_i.sgl)
            data_o = {{(QUAD_W-SGL_W){1'b0}},
                      kind_i.lo_half ? first_w[SGL_W-1:0] : first_w[DBL_W-1:SGL_W]};
        else if (kind_i.quad)
            data_o = {first_w, second_w};
        else
            data_o = {{(QUAD_W-DBL_W){1'b0}}, first_w};
    end

endmodule

// File: rtl/fp_alias_regfile.sv
module fp_alias_regfile
    import fp_alias_pkg::*;
#(
    parameter int SGL_W     = 32,
    parameter int BASE_DBL  = 16,
    parameter int EXT_BANK  = 0,
    localparam int QUAD_W   = 4 * SGL_W,
    localparam int NUM_W    = $clog2(4 * BASE_DBL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_prec,
    input  logic [NUM_W-1:0]  wr_num,
    input  logic [QUAD_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic [1:0]        rd_prec,
    input  logic [NUM_W-1:0]  rd_num,
    output logic [QUAD_W-1:0] rd_data,
    output logic              rd_illegal
);

    localparam int DBL_W   = 2 * SGL_W;
    localparam int NUM_DBL = (EXT_BANK != 0) ? 2 * BASE_DBL : BASE_DBL;
    localparam int DIDX_W  = NUM_W - 1;

    acc_kind_t         wr_kind;
    acc_kind_t         rd_kind;
    logic [DIDX_W-1:0] wr_didx;
    logic [DIDX_W-1:0] rd_didx;
    logic [DBL_W-1:0]  store_q [NUM_DBL];
    logic [DBL_W-1:0]  eff     [NUM_DBL];

    fp_alias_decode #(
        .NUM_W(NUM_W), .NUM_DBL(NUM_DBL), .SGL_LIMIT(2 * BASE_DBL)
    ) u_wr_dec (
        .prec_i(wr_prec), .num_i(wr_num), .kind_o(wr_kind), .didx_o(wr_didx)
    );

    fp_alias_decode #(
        .NUM_W(NUM_W), .NUM_DBL(NUM_DBL), .SGL_LIMIT(2 * BASE_DBL)
    ) u_rd_dec (
        .prec_i(rd_prec), .num_i(rd_num), .kind_o(rd_kind), .didx_o(rd_didx)
    );

    fp_alias_overlay #(
        .SGL_W(SGL_W), .NUM_DBL(NUM_DBL), .DIDX_W(DIDX_W)
    ) u_overlay (
        .cur_i(store_q), .wr_en_i(wr_en), .kind_i(wr_kind),
        .didx_i(wr_didx), .data_i(wr_data), .eff_o(eff)
    );

    fp_alias_bank #(
        .DBL_W(DBL_W), .NUM_DBL(NUM_DBL)
    ) u_bank (
        .clk(clk), .rst(rst), .nxt_i(eff), .q_o(store_q)
    );

    fp_alias_rdmux #(
        .SGL_W(SGL_W), .NUM_DBL(NUM_DBL), .DIDX_W(DIDX_W)
    ) u_rdmux (
        .eff_i(eff), .kind_i(rd_kind), .didx_i(rd_didx), .data_o(rd_data)
    );

    assign wr_illegal = wr_en & ~wr_kind.ok;
    assign rd_illegal = ~rd_kind.ok;

endmodule

// File: rtl/fp_alias_regfile_chk.sv
module fp_alias_regfile_chk #(
    parameter int SGL_W     = 32,
    parameter int BASE_DBL  = 16,
    parameter int EXT_BANK  = 0,
    localparam int QUAD_W   = 4 * SGL_W,
    localparam int NUM_W    = $clog2(4 * BASE_DBL)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_prec,
    input logic [NUM_W-1:0]  wr_num,
    input logic [QUAD_W-1:0] wr_data,
    input logic              wr_illegal,
    input logic [1:0]        rd_prec,
    input logic [NUM_W-1:0]  rd_num,
    input logic [QUAD_W-1:0] rd_data,
    input logic              rd_illegal
);

    localparam int DBL_W = 2 * SGL_W;
    localparam logic [NUM_W:0] BASE_LIM = (NUM_W+1)'(2 * BASE_DBL);

    function automatic logic [QUAD_W-1:0] narrow(logic [1:0] p, logic [QUAD_W-1:0] d);
        case (p)
            2'd0:    return {{(QUAD_W-SGL_W){1'b0}}, d[SGL_W-1:0]};
            2'd1:    return {{(QUAD_W-DBL_W){1'b0}}, d[DBL_W-1:0]};
            default: return d;
        endcase
    endfunction

    p_illegal_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rd_illegal |-> (rd_data == '0));

    p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_prec == 2'd3) |-> rd_illegal);

    p_quad_align_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_prec == 2'd2 && rd_num[1:0] != 2'b00) |-> rd_illegal);

    p_dbl_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_prec == 2'd1 && !rd_illegal) |-> (rd_data[QUAD_W-1:DBL_W] == '0));

    p_sgl_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_prec == 2'd0 && {1'b0, rd_num} >= BASE_LIM) |-> rd_illegal);

    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_illegal && rd_prec == wr_prec && rd_num == wr_num)
            |-> (!rd_illegal && rd_data == narrow(wr_prec, wr_data)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !wr_en && !$past(wr_en) && $stable(rd_prec) && $stable(rd_num))
            |-> $stable(rd_data));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en) |-> (rd_data == '0));

    if (EXT_BANK == 0) begin : g_base_chk
        p_base_limit_r7: assert property (@(posedge clk) disable iff (rst)
            (rd_prec != 2'd0 && {1'b0, rd_num} >= BASE_LIM) |-> rd_illegal);
    end else begin : g_ext_chk
        p_ext_reach_r7: assert property (@(posedge clk) disable iff (rst)
            (rd_prec == 2'd1 && !rd_num[0]) |-> !rd_illegal);
    end

endmodule

bind fp_alias_regfile fp_alias_regfile_chk #(
    .SGL_W(SGL_W), .BASE_DBL(BASE_DBL), .EXT_BANK(EXT_BANK)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_prec(wr_prec), .wr_num(wr_num),
    .wr_data(wr_data), .wr_illegal(wr_illegal), .rd_prec(rd_prec),
    .rd_num(rd_num), .rd_data(rd_data), .rd_illegal(rd_illegal)
);

// File: tb/fp_alias_regfile_bench.sv
module fp_alias_regfile_bench;

    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [1:0]   wr_prec;
    logic [5:0]   wr_num;
    logic [127:0] wr_data;
    logic [1:0]   rd_prec;
    logic [5:0]   rd_num;
    logic [127:0] rd_data_b, rd_data_e;
    logic         rd_ill_b, rd_ill_e, wr_ill_b, wr_ill_e;

    int checks   = 0;
    int failures = 0;

    // model storage: index 0 base build, index 1 extended build
    logic [63:0] mdl [2][32];

    always #(CLK_PER/2) clk = ~clk;

    fp_alias_regfile #(.SGL_W(32), .BASE_DBL(16), .EXT_BANK(0)) u_fp_alias_regfile_base (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_prec(wr_prec), .wr_num(wr_num),
        .wr_data(wr_data), .wr_illegal(wr_ill_b), .rd_prec(rd_prec), .rd_num(rd_num),
        .rd_data(rd_data_b), .rd_illegal(rd_ill_b)
    );

    fp_alias_regfile #(.SGL_W(32), .BASE_DBL(16), .EXT_BANK(1)) u_fp_alias_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_prec(wr_prec), .wr_num(wr_num),
        .wr_data(wr_data), .wr_illegal(wr_ill_e), .rd_prec(rd_prec), .rd_num(rd_num),
        .rd_data(rd_data_e), .rd_illegal(rd_ill_e)
    );

    // reachability per R1, R3, R4, R5, R6, R7
    function automatic bit legal(int c, int p, int n);
        int nd = (c != 0) ? 32 : 16;
        case (p)
            0:       return n < 32;
            1:       return (n % 2 == 0) && (n / 2 < nd);
            2:       return (n % 4 == 0) && (n / 2 + 1 < nd);
            default: return 1'b0;
        endcase
    endfunction

    function automatic void mdl_write(int c, int p, int n, logic [127:0] d);
        if (!legal(c, p, n)) return;
        case (p)
            0: if (n % 2 != 0) mdl[c][n/2][31:0]  = d[31:0];
               else            mdl[c][n/2][63:32] = d[31:0];
            1: mdl[c][n/2] = d[63:0];
            default: begin
                mdl[c][n/2]   = d[127:64];
                mdl[c][n/2+1] = d[63:0];
            end
        endcase
    endfunction

    function automatic logic [127:0] mdl_read(int c, int p, int n);
        if (!legal(c, p, n)) return '0;
        case (p)
            0:       return {96'd0, (n % 2 != 0) ? mdl[c][n/2][31:0] : mdl[c][n/2][63:32]};
            1:       return {64'd0, mdl[c][n/2]};
            default: return {mdl[c][n/2], mdl[c][n/2+1]};
        endcase
    endfunction

    function automatic logic [127:0] pat(int s);
        logic [31:0] k = 32'(s);
        return {k * 32'h9E37_79B1 + 32'h1111_0001, k * 32'h85EB_CA6B + 32'h2222_0002,
                k * 32'hC2B2_AE35 + 32'h3333_0003, k * 32'h27D4_EB2F + 32'h4444_0004};
    endfunction

    // one cycle: drive at falling edge, compare before the rising edge
    task automatic cyc(bit we, int wp, int wn, logic [127:0] wd, int rp, int rn, string tag);
        logic [129:0] act, exp;
        @(negedge clk);
        wr_en   = we;
        wr_prec = 2'(wp);
        wr_num  = 6'(wn);
        wr_data = wd;
        rd_prec = 2'(rp);
        rd_num  = 6'(rn);
        #1;
        for (int c = 0; c < 2; c++) begin
            if (we) mdl_write(c, wp, wn, wd);
            exp = {we && !legal(c, wp, wn), !legal(c, rp, rn), mdl_read(c, rp, rn)};
            act = (c == 0) ? {wr_ill_b, rd_ill_b, rd_data_b} : {wr_ill_e, rd_ill_e, rd_data_e};
            checks++;
            if (act !== exp) begin
                failures++;
                $display("FAIL %s build=%0d wr(p%0d n%0d) rd(p%0d n%0d) actual=%h expected=%h",
                         tag, c, wp, wn, rp, rn, act, exp);
            end
        end
    endtask

    task automatic sweep(string tag);
        for (int p = 0; p < 4; p++)
            for (int n = 0; n < 64; n++)
                cyc(1'b0, 0, 0, '0, p, n, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 32; i++) mdl[c][i] = '0;
    endtask

    initial begin
        #(CLK_PER * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_prec = '0; wr_num = '0; wr_data = '0;
        rd_prec = '0; rd_num = '0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 32; i++) mdl[c][i] = 64'hDEAD_BEEF_DEAD_BEEF;
        do_reset();
        // R9: everything reads zero after reset
        sweep("R9 reset state");

        // R3 R7 R10: write every double, read it back the same cycle and later
        for (int d = 0; d < 32; d++)
            cyc(1'b1, 1, 2 * d, pat(d), 1, 2 * d, "R3 R7 double write");
        sweep("R1 R3 R4 R6 R7 R10 after doubles");

        // R1 R2 R6: single writes keep the sibling half
        for (int n = 0; n < 64; n++)
            cyc(1'b1, 0, n, pat(100 + n), 0, n ^ 1, "R2 single sibling");
        sweep("R1 R2 R6 after singles");

        // R4 R5 R7: quad writes at every number, misaligned ones suppressed
        for (int n = 0; n < 64; n++)
            cyc(1'b1, 2, n, pat(200 + n), 1, n & 62, "R4 quad write");
        sweep("R4 R5 R7 after quads");

        // R5: reserved precision and odd doubles change nothing
        for (int n = 0; n < 64; n++) begin
            cyc(1'b1, 3, n, pat(300 + n), 2, n & 60, "R5 reserved write");
            cyc(1'b1, 1, n | 1, pat(400 + n), 1, n & 62, "R5 odd double write");
        end
        sweep("R5 after illegal writes");

        // R8: write and read in the same cycle at nearby numbers
        for (int wp = 0; wp < 3; wp++)
            for (int wn = 0; wn < 64; wn++)
                for (int rp = 0; rp < 4; rp++)
                    for (int dn = -4; dn <= 4; dn++)
                        cyc(1'b1, wp, wn, pat(wp * 1000 + wn * 16 + rp * 4 + dn + 4),
                            rp, (wn + dn) & 63, "R8 same-cycle overlap");
        sweep("R10 R8 persisted");

        // R9: reset clears a populated file
        do_reset();
        sweep("R9 reset after use");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule